// File: doc/BRIEF.md
# Address Translation Sequencer

This block decides, for a single 32-bit effective address (EA), which translation rule applies and what the result is. The possible results are a physical address with its access rights, a completed no-op, or exactly one fault with its status word. The caller presents a request on a valid/ready channel. The request carries the EA, the access direction (load, store or instruction fetch), the data access class, the privilege mode, the translation-enable flag, and the result of an external block-translation matcher that was evaluated on the same EA. The block reads the sixteen segment registers as a flat vector and issues a page-table lookup to an external walker only when no earlier rule has resolved the request.

The rules are tried in a fixed order. First comes the translation-off bypass, then a block-translation hit, then the segment register selected by the top four EA bits. A direct-store segment is handled on its own. A fetch from a no-execute segment then faults, and after that the walker result and the page protection check decide the outcome. Each failure is encoded as an exception kind with an instruction-fault code, or as a data status word together with the faulting address.

Both the request channel and the result channel are valid/ready. `req_ready` is high only while no request is in flight. A presented result keeps `rsp_valid` and every result field unchanged until the cycle in which `rsp_ready` is high. The walker request channel follows the same holding rule. The walker answers with a single-cycle `walk_rsp_valid` pulse and is never back-pressured.

Top module: `xlate_seq`

## Requirements
- R1: With `req_xlate`=0 the result is pa=EA, prot=3'b111 (bit 2 execute, bit 1 write, bit 0 read), kind 0 (none), and no walker request is issued.
- R2: When translation is on and `req_bat_hit`=1, the block result wins over every segment rule without a walk. If `req_bat_prot` permits the access (fetch needs bit 2, store bit 1, load bit 0), pa=`req_bat_pa` and prot=`req_bat_prot`. Otherwise the protection fault of R11 is raised.
- R3: The segment register is word EA[31:28] of `sr_table`, with word n at bits [32n+31:32n]. Its fields are: bit 31 direct-store, bit 30 supervisor key, bit 29 user key, bit 28 no-execute, bits [27:0] segment tag. A walker request carries that tag on `walk_vsid` and EA[27:12] on `walk_pidx`.
- R4: A fetch from a direct-store segment faults with kind 1 (instruction fault) and code 0x10000000, whatever its class.
- R5: A reservation access (class 2) to a direct-store segment faults with kind 2 (data fault) and status 0x04000000 for a load or 0x06000000 for a store.
- R6: An external-control access (class 4) to a direct-store segment faults with kind 2 and status 0x04100000 for a load or 0x06100000 for a store.
- R7: A floating-point access (class 1) to a direct-store segment gives kind 3 (alignment) with status 0. A cache-control access (class 3) completes with `rsp_nop`=1, kind 0, pa=EA and prot=0.
- R8: An integer access (class 0) to a direct-store segment gets pa=EA. Its rights are read/write (prot 3'b011) when the key is 1 and read-only (3'b001) when the key is 0; a store that is not permitted takes the R11 fault. The key is the user key when `req_user`=1 and the supervisor key otherwise.
- R9: A fetch from a no-execute segment that is not direct-store faults with kind 1 and code 0x10000000, without a walk.
- R10: A walker miss gives kind 1 with code 0x40000000 for a fetch, or kind 2 with status 0x40000000 for a load and 0x42000000 for a store.
- R11: A protection failure gives kind 1 with code 0x08000000 for a fetch, or kind 2 with status 0x08000000 for a load and 0x0A000000 for a store. For page rights with key 0, PP values 0, 1 and 2 give read/write and PP 3 gives read. With key 1, PP 0 gives nothing, PP 1 and 3 give read, and PP 2 gives read/write.
- R12: A permitted walker hit gives pa={`walk_rpn`, EA[11:0]}. Its prot has read and write from R11 and execute equal to read when the segment is not no-execute.
- R13: Every data fault (kind 2 or 3) sets `rsp_dar`=EA and `rsp_isi`=0. An instruction fault leaves `rsp_dsisr` and `rsp_dar` at 0. A fault result has pa=0 and prot=0.
- R14: Each accepted request yields exactly one result, held stable until `rsp_ready`. `req_ready` is low from acceptance until the result is taken, and `walk_req_valid` with its fields stays stable until `walk_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_ea | input | 32 | Effective address |
| req_access | input | 2 | 0 load, 1 store, 2 fetch |
| req_class | input | 3 | 0 integer, 1 float, 2 reservation, 3 cache-control, 4 external-control |
| req_user | input | 1 | 1 user mode, 0 supervisor |
| req_xlate | input | 1 | Translation enabled |
| req_bat_hit | input | 1 | Block-translation matcher hit |
| req_bat_pa | input | 32 | Physical address from the matcher |
| req_bat_prot | input | 3 | Rights from the matcher {x,w,r} |
| sr_table | input | 512 | Sixteen packed segment registers |
| walk_req_valid | output | 1 | Page-table lookup wanted |
| walk_req_ready | input | 1 | Walker takes the lookup |
| walk_vsid | output | 28 | Segment tag for the lookup |
| walk_pidx | output | 16 | Page index EA[27:12] |
| walk_rsp_valid | input | 1 | One-cycle walker answer |
| walk_hit | input | 1 | Entry found |
| walk_rpn | input | 20 | Real page number |
| walk_pp | input | 2 | Page protection bits |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_pa | output | 32 | Physical address |
| rsp_prot | output | 3 | Granted rights {x,w,r} |
| rsp_kind | output | 2 | 0 none, 1 instruction fault, 2 data fault, 3 alignment |
| rsp_isi | output | 32 | Instruction-fault code |
| rsp_dsisr | output | 32 | Data-fault status word |
| rsp_dar | output | 32 | Faulting address for data faults |
| rsp_nop | output | 1 | Access completes as a no-op |

## Verification
The assertions take for granted that `sr_table` and the request payload do not change the result of a request while it is in flight. They also assume that `walk_rsp_valid` pulses once, only after a walker request has been taken and before the result appears. The stimulus writes new segment registers only between transactions. It answers each walker handshake with one pulse after a random delay of 0 to 3 cycles, and inserts random stalls on `walk_req_ready` and `rsp_ready` so that the holding rules are exercised.

// File: rtl/xlate_seq_pkg.sv
package xlate_seq_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    CLS_INT   = 3'd0,
    CLS_FLOAT = 3'd1,
    CLS_RSV   = 3'd2,
    CLS_CACHE = 3'd3,
    CLS_EXT   = 3'd4
  } cls_e;

  typedef enum logic [1:0] {
    FK_NONE  = 2'd0,
    FK_ISI   = 2'd1,
    FK_DSI   = 2'd2,
    FK_ALIGN = 2'd3
  } fkind_e;

  typedef enum logic [2:0] {
    CA_NONE,
    CA_MISS,
    CA_PROT,
    CA_NOEXEC,
    CA_DS_RSV,
    CA_DS_EXT,
    CA_DS_FP
  } cause_e;

  // segment register field positions (decoded by neighbouring logic too)
  localparam int SR_DS_BIT = 31;
  localparam int SR_KS_BIT = 30;
  localparam int SR_KP_BIT = 29;
  localparam int SR_NX_BIT = 28;

  // rights vector layout {x,w,r}
  localparam int PR_X = 2;
  localparam int PR_W = 1;
  localparam int PR_R = 0;

  localparam logic [31:0] CODE_MISS     = 32'h4000_0000;
  localparam logic [31:0] CODE_MISS_ST  = 32'h4200_0000;
  localparam logic [31:0] CODE_PROT     = 32'h0800_0000;
  localparam logic [31:0] CODE_PROT_ST  = 32'h0A00_0000;
  localparam logic [31:0] CODE_NOEXEC   = 32'h1000_0000;
  localparam logic [31:0] CODE_RSV_LD   = 32'h0400_0000;
  localparam logic [31:0] CODE_RSV_ST   = 32'h0600_0000;
  localparam logic [31:0] CODE_EXT_LD   = 32'h0410_0000;
  localparam logic [31:0] CODE_EXT_ST   = 32'h0610_0000;

  typedef struct packed {
    logic ds;
    logic ks;
    logic kp;
    logic nx;
  } seg_flags_t;

  function automatic logic rights_permit(input logic [2:0] p, input acc_e a);
    case (a)
      ACC_FETCH: rights_permit = p[PR_X];
      ACC_STORE: rights_permit = p[PR_W];
      default:   rights_permit = p[PR_R];
    endcase
  endfunction

endpackage

// File: rtl/xlate_seg_pick.sv
module xlate_seg_pick
  import xlate_seq_pkg::*;
#(
  parameter int SR_W     = 32,
  parameter int SEG_BITS = 4,
  localparam int SEG_CNT = 1 << SEG_BITS,
  localparam int TAG_W   = SR_W - 4
) (
  input  logic [SEG_CNT*SR_W-1:0] sr_table,
  input  logic [SEG_BITS-1:0]     seg_idx,
  output seg_flags_t              flags,
  output logic [TAG_W-1:0]        tag
);

  logic [SR_W-1:0] sr_arr [SEG_CNT];
  logic [SR_W-1:0] sel;

  for (genvar g = 0; g < SEG_CNT; g++) begin : g_unpack
    assign sr_arr[g] = sr_table[g*SR_W +: SR_W];
  end

  assign sel      = sr_arr[seg_idx];
  assign flags.ds = sel[SR_DS_BIT];
  assign flags.ks = sel[SR_KS_BIT];
  assign flags.kp = sel[SR_KP_BIT];
  assign flags.nx = sel[SR_NX_BIT];
  assign tag      = sel[TAG_W-1:0];

endmodule

// File: rtl/xlate_pp_eval.sv
module xlate_pp_eval (
  input  logic       key,
  input  logic [1:0] pp,
  output logic       rd,
  output logic       wr
);

  always_comb begin
    rd = 1'b0;
    wr = 1'b0;
    case ({key, pp})
      3'b000, 3'b001, 3'b010: begin rd = 1'b1; wr = 1'b1; end
      3'b011:                 begin rd = 1'b1; end
      3'b100:                 begin end
      3'b101, 3'b111:         begin rd = 1'b1; end
      3'b110:                 begin rd = 1'b1; wr = 1'b1; end
      default:                begin end
    endcase
  end

endmodule

// File: rtl/xlate_fault_enc.sv
module xlate_fault_enc
  import xlate_seq_pkg::*;
#(
  parameter int EA_W = 32
) (
  input  cause_e            cause,
  input  acc_e              acc,
  input  logic [EA_W-1:0]   ea,
  output fkind_e            kind,
  output logic [31:0]       isi,
  output logic [31:0]       dsisr,
  output logic [EA_W-1:0]   dar
);

  logic st;
  assign st = (acc == ACC_STORE);

  always_comb begin
    kind  = FK_NONE;
    isi   = '0;
    dsisr = '0;
    dar   = '0;
    if (cause != CA_NONE) begin
      if (acc == ACC_FETCH) begin
        kind = FK_ISI;
        case (cause)
          CA_MISS: isi = CODE_MISS;
          CA_PROT: isi = CODE_PROT;
          default: isi = CODE_NOEXEC;
        endcase
      end else begin
        kind = FK_DSI;
        dar  = ea;
        case (cause)
          CA_MISS:   dsisr = st ? CODE_MISS_ST : CODE_MISS;
          CA_PROT:   dsisr = st ? CODE_PROT_ST : CODE_PROT;
          CA_DS_RSV: dsisr = st ? CODE_RSV_ST  : CODE_RSV_LD;
          CA_DS_EXT: dsisr = st ? CODE_EXT_ST  : CODE_EXT_LD;
          CA_DS_FP:  kind  = FK_ALIGN;
          default:   dsisr = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/xlate_seq.sv
module xlate_seq
  import xlate_seq_pkg::*;
#(
  parameter int EA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int SEG_BITS  = 4,
  parameter int SR_W      = 32,
  localparam int SEG_CNT  = 1 << SEG_BITS,
  localparam int RPN_W    = EA_W - PAGE_BITS,
  localparam int PIDX_W   = EA_W - SEG_BITS - PAGE_BITS,
  localparam int TAG_W    = SR_W - 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [EA_W-1:0]          req_ea,
  input  logic [1:0]               req_access,
  input  logic [2:0]               req_class,
  input  logic                     req_user,
  input  logic                     req_xlate,
  input  logic                     req_bat_hit,
  input  logic [EA_W-1:0]          req_bat_pa,
  input  logic [2:0]               req_bat_prot,
  input  logic [SEG_CNT*SR_W-1:0]  sr_table,
  output logic                     walk_req_valid,
  input  logic                     walk_req_ready,
  output logic [TAG_W-1:0]         walk_vsid,
  output logic [PIDX_W-1:0]        walk_pidx,
  input  logic                     walk_rsp_valid,
  input  logic                     walk_hit,
  input  logic [RPN_W-1:0]         walk_rpn,
  input  logic [1:0]               walk_pp,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [EA_W-1:0]          rsp_pa,
  output logic [2:0]               rsp_prot,
  output logic [1:0]               rsp_kind,
  output logic [31:0]              rsp_isi,
  output logic [31:0]              rsp_dsisr,
  output logic [EA_W-1:0]          rsp_dar,
  output logic                     rsp_nop
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_EVAL, ST_WREQ, ST_WWAIT, ST_POST, ST_RESP
  } state_e;

  state_e state_q, state_d;

  // captured request
  logic [EA_W-1:0]  ea_q;
  acc_e             acc_q;
  cls_e             cls_q;
  logic             user_q, xlate_q, bhit_q;
  logic [EA_W-1:0]  bpa_q;
  logic [2:0]       bprot_q;
  // captured walker answer
  logic             whit_q;
  logic [RPN_W-1:0] wrpn_q;
  logic [1:0]       wpp_q;

  // segment decode
  seg_flags_t       seg;
  logic [TAG_W-1:0] seg_tag;
  logic             key;

  xlate_seg_pick #(.SR_W(SR_W), .SEG_BITS(SEG_BITS)) u_seg (
    .sr_table (sr_table),
    .seg_idx  (ea_q[EA_W-1 -: SEG_BITS]),
    .flags    (seg),
    .tag      (seg_tag)
  );

  assign key = user_q ? seg.kp : seg.ks;

  logic pg_rd, pg_wr;
  xlate_pp_eval u_pp (
    .key (key),
    .pp  (wpp_q),
    .rd  (pg_rd),
    .wr  (pg_wr)
  );

  // rule ordering
  cause_e          cause;
  logic [EA_W-1:0] ok_pa;
  logic [2:0]      ok_prot;
  logic            ok_nop;
  logic            need_walk;
  logic [2:0]      ds_prot, pg_prot;

  assign ds_prot = key ? 3'b011 : 3'b001;
  assign pg_prot = {pg_rd & ~seg.nx, pg_wr, pg_rd};

  always_comb begin
    cause     = CA_NONE;
    ok_pa     = '0;
    ok_prot   = '0;
    ok_nop    = 1'b0;
    need_walk = 1'b0;
    if (!xlate_q) begin
      ok_pa   = ea_q;
      ok_prot = 3'b111;
    end else if (bhit_q) begin
      if (rights_permit(bprot_q, acc_q)) begin
        ok_pa   = bpa_q;
        ok_prot = bprot_q;
      end else begin
        cause = CA_PROT;
      end
    end else if (seg.ds) begin
      if (acc_q == ACC_FETCH) begin
        cause = CA_NOEXEC;
      end else begin
        case (cls_q)
          CLS_FLOAT: cause = CA_DS_FP;
          CLS_RSV:   cause = CA_DS_RSV;
          CLS_EXT:   cause = CA_DS_EXT;
          CLS_CACHE: begin
            ok_nop = 1'b1;
            ok_pa  = ea_q;
          end
          default: begin
            if (rights_permit(ds_prot, acc_q)) begin
              ok_pa   = ea_q;
              ok_prot = ds_prot;
            end else begin
              cause = CA_PROT;
            end
          end
        endcase
      end
    end else if ((acc_q == ACC_FETCH) && seg.nx) begin
      cause = CA_NOEXEC;
    end else if (state_q != ST_POST) begin
      need_walk = 1'b1;
    end else if (!whit_q) begin
      cause = CA_MISS;
    end else if (rights_permit(pg_prot, acc_q)) begin
      ok_pa   = {wrpn_q, ea_q[PAGE_BITS-1:0]};
      ok_prot = pg_prot;
    end else begin
      cause = CA_PROT;
    end
  end

  fkind_e          f_kind;
  logic [31:0]     f_isi, f_dsisr;
  logic [EA_W-1:0] f_dar;

  xlate_fault_enc #(.EA_W(EA_W)) u_enc (
    .cause (cause),
    .acc   (acc_q),
    .ea    (ea_q),
    .kind  (f_kind),
    .isi   (f_isi),
    .dsisr (f_dsisr),
    .dar   (f_dar)
  );

  logic finish;
  assign finish = ((state_q == ST_EVAL) && !need_walk) || (state_q == ST_POST);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_valid)      state_d = ST_EVAL;
      ST_EVAL:  state_d = need_walk ? ST_WREQ : ST_RESP;
      ST_WREQ:  if (walk_req_ready) state_d = ST_WWAIT;
      ST_WWAIT: if (walk_rsp_valid) state_d = ST_POST;
      ST_POST:  state_d = ST_RESP;
      ST_RESP:  if (rsp_ready)      state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ea_q    <= '0;
      acc_q   <= ACC_LOAD;
      cls_q   <= CLS_INT;
      user_q  <= 1'b0;
      xlate_q <= 1'b0;
      bhit_q  <= 1'b0;
      bpa_q   <= '0;
      bprot_q <= '0;
      whit_q  <= 1'b0;
      wrpn_q  <= '0;
      wpp_q   <= '0;
    end else begin
      state_q <= state_d;
      if ((state_q == ST_IDLE) && req_valid) begin
        ea_q    <= req_ea;
        acc_q   <= acc_e'(req_access);
        cls_q   <= cls_e'(req_class);
        user_q  <= req_user;
        xlate_q <= req_xlate;
        bhit_q  <= req_bat_hit;
        bpa_q   <= req_bat_pa;
        bprot_q <= req_bat_prot;
      end
      if ((state_q == ST_WWAIT) && walk_rsp_valid) begin
        whit_q <= walk_hit;
        wrpn_q <= walk_rpn;
        wpp_q  <= walk_pp;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_pa    <= '0;
      rsp_prot  <= '0;
      rsp_kind  <= FK_NONE;
      rsp_isi   <= '0;
      rsp_dsisr <= '0;
      rsp_dar   <= '0;
      rsp_nop   <= 1'b0;
    end else if (finish) begin
      rsp_pa    <= (cause == CA_NONE) ? ok_pa : '0;
      rsp_prot  <= (cause == CA_NONE) ? ok_prot : 3'b000;
      rsp_kind  <= f_kind;
      rsp_isi   <= f_isi;
      rsp_dsisr <= f_dsisr;
      rsp_dar   <= f_dar;
      rsp_nop   <= ok_nop;
    end
  end

  assign req_ready      = (state_q == ST_IDLE);
  assign rsp_valid      = (state_q == ST_RESP);
  assign walk_req_valid = (state_q == ST_WREQ);
  assign walk_vsid      = seg_tag;
  assign walk_pidx      = ea_q[PAGE_BITS +: PIDX_W];

endmodule

// File: rtl/xlate_seq_chk.sv
module xlate_seq_chk
  import xlate_seq_pkg::*;
#(
  parameter int EA_W   = 32,
  parameter int TAG_W  = 28,
  parameter int PIDX_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [EA_W-1:0]   req_ea,
  input logic [1:0]        req_access,
  input logic              req_xlate,
  input logic              req_bat_hit,
  input logic              walk_req_valid,
  input logic              walk_req_ready,
  input logic [TAG_W-1:0]  walk_vsid,
  input logic [PIDX_W-1:0] walk_pidx,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [EA_W-1:0]   rsp_pa,
  input logic [2:0]        rsp_prot,
  input logic [1:0]        rsp_kind,
  input logic [31:0]       rsp_isi,
  input logic [31:0]       rsp_dsisr,
  input logic [EA_W-1:0]   rsp_dar,
  input logic              rsp_nop
);

  logic [EA_W-1:0] cap_ea;
  logic [1:0]      cap_acc;
  logic            cap_xlate, cap_bhit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_ea    <= '0;
      cap_acc   <= '0;
      cap_xlate <= 1'b1;
      cap_bhit  <= 1'b0;
    end else if (req_valid && req_ready) begin
      cap_ea    <= req_ea;
      cap_acc   <= req_access;
      cap_xlate <= req_xlate;
      cap_bhit  <= req_bat_hit;
    end
  end

  // R1
  real_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !cap_xlate |-> rsp_pa == cap_ea && rsp_prot == 3'b111 && rsp_kind == 2'd0);

  // R1
  walk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid |-> cap_xlate && !cap_bhit);

  // R13
  data_dar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind[1] |-> rsp_dar == cap_ea && rsp_isi == 32'd0 && rsp_prot == 3'b000);

  // R13
  isi_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == 2'd1 |-> cap_acc == 2'd2 && rsp_dsisr == 32'd0 && rsp_dar == '0);

  // R7
  nop_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_nop |-> rsp_kind == 2'd0 && rsp_prot == 3'b000);

  // R14
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_kind)
      && $stable(rsp_dsisr) && $stable(rsp_isi) && $stable(rsp_prot));

  // R14
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid && !walk_req_ready |=> walk_req_valid && $stable(walk_vsid) && $stable(walk_pidx));

  // R14
  one_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (rsp_valid || walk_req_valid)));

endmodule

bind xlate_seq xlate_seq_chk #(.EA_W(EA_W), .TAG_W(TAG_W), .PIDX_W(PIDX_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_ea         (req_ea),
  .req_access     (req_access),
  .req_xlate      (req_xlate),
  .req_bat_hit    (req_bat_hit),
  .walk_req_valid (walk_req_valid),
  .walk_req_ready (walk_req_ready),
  .walk_vsid      (walk_vsid),
  .walk_pidx      (walk_pidx),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_pa         (rsp_pa),
  .rsp_prot       (rsp_prot),
  .rsp_kind       (rsp_kind),
  .rsp_isi        (rsp_isi),
  .rsp_dsisr      (rsp_dsisr),
  .rsp_dar        (rsp_dar),
  .rsp_nop        (rsp_nop)
);

// File: tb/xlate_seq_tb_top.sv
`timescale 1ns/1ps
module xlate_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         req_valid = 0, req_ready;
  logic [31:0]  req_ea = 0;
  logic [1:0]   req_access = 0;
  logic [2:0]   req_class = 0;
  logic         req_user = 0, req_xlate = 0, req_bat_hit = 0;
  logic [31:0]  req_bat_pa = 0;
  logic [2:0]   req_bat_prot = 0;
  logic [511:0] sr_table = '0;
  logic         walk_req_valid, walk_req_ready = 0;
  logic [27:0]  walk_vsid;
  logic [15:0]  walk_pidx;
  logic         walk_rsp_valid = 0, walk_hit = 0;
  logic [19:0]  walk_rpn = 0;
  logic [1:0]   walk_pp = 0;
  logic         rsp_valid, rsp_ready = 0;
  logic [31:0]  rsp_pa, rsp_isi, rsp_dsisr, rsp_dar;
  logic [2:0]   rsp_prot;
  logic [1:0]   rsp_kind;
  logic         rsp_nop;

  xlate_seq dut_i (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  typedef struct packed {
    logic [31:0] pa;
    logic [2:0]  prot;
    logic [1:0]  kind;
    logic [31:0] isi;
    logic [31:0] dsisr;
    logic [31:0] dar;
    logic        nop;
    logic        walk;
  } exp_t;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic permit(input logic [2:0] p, input logic [1:0] a);
    return (a == 2'd2) ? p[2] : (a == 2'd1) ? p[1] : p[0];
  endfunction

  function automatic void prot_fault(inout exp_t e, input logic [1:0] a, input logic [31:0] ea);
    if (a == 2'd2) begin e.kind = 2'd1; e.isi = 32'h0800_0000; end
    else begin e.kind = 2'd2; e.dar = ea; e.dsisr = (a == 2'd1) ? 32'h0A00_0000 : 32'h0800_0000; end
  endfunction

  function automatic exp_t model(input logic [31:0] ea, input logic [1:0] a, input logic [2:0] cls,
      input logic user, input logic xl, input logic bh, input logic [31:0] bpa, input logic [2:0] bp,
      input logic [31:0] sr, input logic wh, input logic [19:0] rpn, input logic [1:0] pp, output string tag);
    exp_t e;
    logic key, rd, wr;
    logic [2:0] p;
    e = '0;
    key = user ? sr[29] : sr[30];
    if (!xl) begin
      tag = "R1"; e.pa = ea; e.prot = 3'b111;
    end else if (bh) begin
      tag = "R2";
      if (permit(bp, a)) begin e.pa = bpa; e.prot = bp; end else prot_fault(e, a, ea);
    end else if (sr[31]) begin
      if (a == 2'd2) begin tag = "R4"; e.kind = 2'd1; e.isi = 32'h1000_0000; end
      else case (cls)
        3'd1: begin tag = "R7"; e.kind = 2'd3; e.dar = ea; end
        3'd2: begin tag = "R5"; e.kind = 2'd2; e.dar = ea; e.dsisr = (a == 2'd1) ? 32'h0600_0000 : 32'h0400_0000; end
        3'd3: begin tag = "R7"; e.nop = 1'b1; e.pa = ea; end
        3'd4: begin tag = "R6"; e.kind = 2'd2; e.dar = ea; e.dsisr = (a == 2'd1) ? 32'h0610_0000 : 32'h0410_0000; end
        default: begin
          tag = "R8"; p = key ? 3'b011 : 3'b001;
          if (permit(p, a)) begin e.pa = ea; e.prot = p; end else prot_fault(e, a, ea);
        end
      endcase
    end else if (a == 2'd2 && sr[28]) begin
      tag = "R9"; e.kind = 2'd1; e.isi = 32'h1000_0000;
    end else begin
      e.walk = 1'b1;
      if (!wh) begin
        tag = "R10";
        if (a == 2'd2) begin e.kind = 2'd1; e.isi = 32'h4000_0000; end
        else begin e.kind = 2'd2; e.dar = ea; e.dsisr = (a == 2'd1) ? 32'h4200_0000 : 32'h4000_0000; end
      end else begin
        if (!key) begin rd = 1'b1; wr = (pp != 2'd3); end
        else begin rd = (pp != 2'd0); wr = (pp == 2'd2); end
        p = {rd & ~sr[28], wr, rd};
        if (permit(p, a)) begin tag = "R12"; e.pa = {rpn, ea[11:0]}; e.prot = p; end
        else begin tag = "R11"; prot_fault(e, a, ea); end
      end
    end
    return e;
  endfunction

  task automatic run_txn(input logic [31:0] ea, input logic [1:0] a, input logic [2:0] cls,
      input logic user, input logic xl, input logic bh, input logic [31:0] bpa, input logic [2:0] bp,
      input logic wh, input logic [19:0] rpn, input logic [1:0] pp);
    exp_t e;
    string tag;
    logic [31:0] sr;
    bit done, walked;
    int n;
    sr = sr_table[ea[31:28]*32 +: 32];
    e = model(ea, a, cls, user, xl, bh, bpa, bp, sr, wh, rpn, pp, tag);
    while (!req_ready) @(negedge clk);
    req_ea = ea; req_access = a; req_class = cls; req_user = user; req_xlate = xl;
    req_bat_hit = bh; req_bat_pa = bpa; req_bat_prot = bp; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R14", "req_ready busy", {31'd0, req_ready}, 32'd0);
    done = 0; walked = 0; n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
      if (walk_req_valid) begin
        walk_req_ready = 1'($urandom_range(0, 1));
        if (walk_req_ready) begin
          walked = 1;
          chk("R3", "walk_vsid", {4'd0, walk_vsid}, {4'd0, sr[27:0]});
          chk("R3", "walk_pidx", {16'd0, walk_pidx}, {16'd0, ea[27:12]});
          @(negedge clk);
          walk_req_ready = 1'b0;
          repeat ($urandom_range(0, 3)) @(negedge clk);
          walk_hit = wh; walk_rpn = rpn; walk_pp = pp; walk_rsp_valid = 1'b1;
          @(negedge clk);
          walk_rsp_valid = 1'b0;
        end
      end else if (rsp_valid) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        chk(tag, "pa", rsp_pa, e.pa);
        chk(tag, "prot", {29'd0, rsp_prot}, {29'd0, e.prot});
        chk(tag, "kind", {30'd0, rsp_kind}, {30'd0, e.kind});
        chk(tag, "isi", rsp_isi, e.isi);
        chk(tag, "dsisr", rsp_dsisr, e.dsisr);
        chk("R13", "dar", rsp_dar, e.dar);
        chk("R7", "nop", {31'd0, rsp_nop}, {31'd0, e.nop});
        chk(tag, "walk issued", {31'd0, walked}, {31'd0, e.walk});
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        done = 1;
      end
    end
    if (!done) chk("R14", "response missing", 32'd0, 32'd1);
  endtask

  task automatic set_sr(input int idx, input logic [31:0] v);
    sr_table[idx*32 +: 32] = v;
  endtask

  initial begin
    #400000;
    if (!ended) begin
      n_bad++; n_chk++;
      $display("FAIL R14 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R14", "reset req_ready", {31'd0, req_ready}, 32'd1);
    chk("R14", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R14", "reset walk_req_valid", {31'd0, walk_req_valid}, 32'd0);

    // directed: segment 1 plain, 2 direct-store key1, 3 direct-store key0, 4 no-exec
    set_sr(1, 32'h0ABC_DEF1);
    set_sr(2, 32'hE000_0002);
    set_sr(3, 32'h8000_0003);
    set_sr(4, 32'h1123_4567);
    run_txn(32'h1234_5678, 2'd1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0);               // R1
    run_txn(32'h1000_0010, 2'd0, 3'd0, 0, 1, 1, 32'hCAFE_0000, 3'b001, 0, 0, 0); // R2 ok
    run_txn(32'h1000_0010, 2'd1, 3'd0, 0, 1, 1, 32'hCAFE_0000, 3'b001, 0, 0, 0); // R2 denied
    run_txn(32'h2000_0040, 2'd2, 3'd0, 0, 1, 0, 0, 0, 0, 0, 0);               // R4
    run_txn(32'h2000_0044, 2'd0, 3'd2, 0, 1, 0, 0, 0, 0, 0, 0);               // R5
    run_txn(32'h2000_0048, 2'd1, 3'd2, 0, 1, 0, 0, 0, 0, 0, 0);               // R5
    run_txn(32'h2000_004C, 2'd0, 3'd4, 0, 1, 0, 0, 0, 0, 0, 0);               // R6
    run_txn(32'h2000_0050, 2'd1, 3'd4, 0, 1, 0, 0, 0, 0, 0, 0);               // R6
    run_txn(32'h2000_0054, 2'd1, 3'd1, 0, 1, 0, 0, 0, 0, 0, 0);               // R7 float
    run_txn(32'h2000_0058, 2'd1, 3'd3, 0, 1, 0, 0, 0, 0, 0, 0);               // R7 cache
    run_txn(32'h2000_005C, 2'd1, 3'd0, 0, 1, 0, 0, 0, 0, 0, 0);               // R8 key1 store ok
    run_txn(32'h3000_0060, 2'd1, 3'd0, 0, 1, 0, 0, 0, 0, 0, 0);               // R8 key0 store denied
    run_txn(32'h3000_0064, 2'd0, 3'd0, 0, 1, 0, 0, 0, 0, 0, 0);               // R8 key0 load ok
    run_txn(32'h4000_0070, 2'd2, 3'd0, 0, 1, 0, 0, 0, 1, 20'h1, 2'd2);        // R9
    run_txn(32'h4000_0074, 2'd0, 3'd0, 0, 1, 0, 0, 0, 1, 20'hABCDE, 2'd2);    // R12 nx data
    run_txn(32'h1000_1000, 2'd2, 3'd0, 0, 1, 0, 0, 0, 0, 0, 0);               // R10
    run_txn(32'h1000_1004, 2'd0, 3'd0, 0, 1, 0, 0, 0, 0, 0, 0);               // R10
    run_txn(32'h1000_1008, 2'd1, 3'd0, 0, 1, 0, 0, 0, 0, 0, 0);               // R10
    for (int u = 0; u < 2; u++)                                               // R11 / R12 PP table
      for (int p = 0; p < 4; p++) begin
        run_txn(32'h1FFF_F123, 2'd1, 3'd0, 1'(u), 1, 0, 0, 0, 1, 20'h5A5A5, 2'(p));
        run_txn(32'h1FFF_F123, 2'd0, 3'd0, 1'(u), 1, 0, 0, 0, 1, 20'h5A5A5, 2'(p));
      end

    // constrained random
    for (int i = 0; i < 400; i++) begin
      for (int s = 0; s < 16; s++) begin
        logic [31:0] v;
        v = $urandom;
        v[31] = ($urandom_range(0, 4) == 0);
        v[28] = ($urandom_range(0, 3) == 0);
        set_sr(s, v);
      end
      run_txn($urandom, 2'($urandom_range(0, 2)), 3'($urandom_range(0, 4)), 1'($urandom_range(0, 1)),
              ($urandom_range(0, 7) != 0), ($urandom_range(0, 4) == 0), $urandom, 3'($urandom_range(0, 7)),
              ($urandom_range(0, 3) != 0), 20'($urandom), 2'($urandom_range(0, 3)));
    end

    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule